// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is a single comparator channel for a high-resolution event timer. A free-running 64-bit main counter is supplied from outside. The channel compares that counter with a programmed comparator value. When the counter reaches the comparator, the channel emits a one-cycle interrupt pulse. Software configures the channel and reads it back through a 32-bit word-addressed register port. The interrupt is produced only while the channel's own enable bit and a chip-level global enable input are both high.

The channel runs in one-shot or periodic mode, with either the full 64-bit width or a 32-bit narrow width.

- In periodic mode, a write to a comparator word normally loads a hidden period register. The comparator is then pushed forward by that period after every match.
- A self-clearing value-set bit redirects the next comparator write to the comparator itself.
- In narrow one-shot mode, the channel raises one extra pulse when the low 32 bits of the counter pass all-ones before the match. It then still waits for the match.

The channel arms on any comparator-word write made while the global enable is high. It also arms on a rising global enable, provided the comparator is not all ones. Evaluation begins two clock cycles after the arming event. Each pulse appears on `irq_o` one cycle after the clock edge at which the counter value that caused it was sampled.

Top module: `evt_cmp_chan`

## Requirements
- R1: In one-shot mode an armed channel fires one pulse once the counter is at or past the comparator, where "reached" means the signed difference counter minus comparator is non-negative in the active width. The channel then disarms and gives no further pulses.
- R2: The register words are: 0 configuration, 1 capability, 2 comparator low half, 3 comparator high half. A write to word 2 or 3 in periodic mode with value-set clear loads that half of the period. In any other case it loads that half of the comparator. Words 2 and 3 always read the comparator. A write to one half leaves the other half unchanged.
- R3: The value-set bit (configuration bit 6) reads as zero after any write to word 2 or 3.
- R4: When narrow mode is selected (configuration bit 9), the stored comparator and period are truncated to their low 32 bits. Word 3 then reads zero, and all matching uses only the low 32 bits of the counter.
- R5: Every value loaded into the period has the top bit of the active width forced to zero: bit 31 in narrow mode, bit 63 in wide mode.
- R6: A pulse is emitted only when the channel enable (configuration bit 2) and `glb_en_i` are both high. A rising `glb_en_i` arms the channel when the comparator is not all ones.
- R7: In periodic mode (configuration bit 3) with a non-zero period, each match fires one pulse and advances the comparator by the period. The advance takes one step per cycle. While the counter remains strictly past the new comparator, further steps are taken silently, until the comparator lies at or ahead of the counter.
- R8: A narrow one-shot channel armed while the comparator's low word is below the counter's low word, and still ahead in signed terms, fires an extra pulse when the counter's low word reaches all-ones or wraps. It then fires again at the comparator match.
- R9: In the configuration word, only bits 1, 2, 3, 6 and 9 to 13 (mask 0x3E4E) are writable. Bits 4 and 5 always read one. Word 1 always reads 0x00000C20, and writes to it have no effect.
- R10: After reset, the configuration word reads 0x30, the comparator reads all ones, the period is zero and `irq_o` is low.
- R11: The level-trigger bit (configuration bit 1) is stored and read back but has no effect: a match still yields a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| glb_en_i | input | 1 | Global enable for matching and interrupts |
| cnt_i | input | 64 | Main counter value |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word select |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` (combinational) |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench aims at the places where a channel silently produces the wrong number of pulses:

- **Periodic catch-up.** After a large counter jump, a design that fires on every catch-up step shows extra pulses. A design that advances only once fires again at once.
- **Narrow wrap.** A design that misses the wrap loses the early pulse. A design that skips the match after the wrap loses the second pulse.
- **Period clamp.** An unclamped top bit stores a period that pushes the next match half a range away, so the expected second pulse never comes.
- **Write routing.** A routing error leaves the comparator readback wrong, or a lost value-set clear leaves bit 6 set.
- **Gating and re-arming.** A channel that ignores either enable, or fails to re-arm when the global enable rises, is caught by pulses appearing or missing at the ports.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;
  localparam int unsigned CFG_LEVEL  = 1;
  localparam int unsigned CFG_EN     = 2;
  localparam int unsigned CFG_PER    = 3;
  localparam int unsigned CFG_SETV   = 6;
  localparam int unsigned CFG_NARROW = 9;

  localparam logic [31:0] CFG_WR_MASK = 32'h0000_3E4E;
  localparam logic [31:0] CFG_RO_ONES = 32'h0000_0030;
  localparam logic [31:0] CAP_WORD    = 32'h0000_0C20;

  typedef enum logic [2:0] {
    W_CFG    = 3'd0,
    W_CAP    = 3'd1,
    W_CMP_LO = 3'd2,
    W_CMP_HI = 3'd3
  } word_e;
endpackage

// File: rtl/evt_cmp_regs.sv
module evt_cmp_regs
  import evt_cmp_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int CNT_W  = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              adv_i,
  input  logic [CNT_W-1:0]  adv_val_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              chan_en_o,
  output logic              periodic_o,
  output logic              narrow_o,
  output logic              setval_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [CNT_W-1:0]  per_o,
  output logic              cmp_wr_o
);
  localparam logic [DATA_W-1:0] WR_MASK = DATA_W'(CFG_WR_MASK);
  localparam logic [DATA_W-1:0] RO_ONES = DATA_W'(CFG_RO_ONES);
  localparam logic [DATA_W-1:0] CAP_VAL = DATA_W'(CAP_WORD);

  logic [DATA_W-1:0] cfg_q;
  logic [CNT_W-1:0]  cmp_q, per_q;
  logic wr_cfg, wr_lo, wr_hi, to_cmp;
  logic [DATA_W-1:0] lo_per, hi_per, hi_cmp;

  assign wr_cfg   = wr_en_i && (addr_i == W_CFG);
  assign wr_lo    = wr_en_i && (addr_i == W_CMP_LO);
  assign wr_hi    = wr_en_i && (addr_i == W_CMP_HI);
  assign cmp_wr_o = wr_lo || wr_hi;

  assign chan_en_o  = cfg_q[CFG_EN];
  assign periodic_o = cfg_q[CFG_PER];
  assign narrow_o   = cfg_q[CFG_NARROW];
  assign setval_o   = cfg_q[CFG_SETV];

  assign to_cmp = !periodic_o || setval_o;
  // period clamp: top bit of the active width forced low
  assign lo_per = narrow_o ? {1'b0, wdata_i[DATA_W-2:0]} : wdata_i;
  assign hi_per = narrow_o ? '0 : {1'b0, wdata_i[DATA_W-2:0]};
  assign hi_cmp = narrow_o ? '0 : wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      cmp_q <= '1;
      per_q <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_q <= wdata_i & WR_MASK;
        if (wdata_i[CFG_NARROW]) begin
          cmp_q <= {{DATA_W{1'b0}}, cmp_q[DATA_W-1:0]};
          per_q <= {{(DATA_W+1){1'b0}}, per_q[DATA_W-2:0]};
        end
      end
      if (cmp_wr_o) cfg_q[CFG_SETV] <= 1'b0;
      if (wr_lo) begin
        if (to_cmp) cmp_q[DATA_W-1:0] <= wdata_i;
        else        per_q[DATA_W-1:0] <= lo_per;
      end else if (wr_hi) begin
        if (to_cmp) cmp_q[CNT_W-1:DATA_W] <= hi_cmp;
        else        per_q[CNT_W-1:DATA_W] <= hi_per;
      end else if (adv_i && !wr_cfg) begin
        cmp_q <= adv_val_i;
      end
    end
  end

  always_comb begin
    case (addr_i)
      W_CFG:    rdata_o = cfg_q | RO_ONES;
      W_CAP:    rdata_o = CAP_VAL;
      W_CMP_LO: rdata_o = cmp_q[DATA_W-1:0];
      W_CMP_HI: rdata_o = cmp_q[CNT_W-1:DATA_W];
      default:  rdata_o = '0;
    endcase
  end

  assign cmp_o = cmp_q;
  assign per_o = per_q;
endmodule

// File: rtl/evt_cmp_match.sv
module evt_cmp_match #(
  parameter  int DATA_W = 32,
  localparam int CNT_W  = 2 * DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             glb_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             chan_en_i,
  input  logic             periodic_i,
  input  logic             narrow_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic             cmp_wr_i,
  output logic             adv_o,
  output logic [CNT_W-1:0] adv_val_o,
  output logic             irq_o
);
  logic [DATA_W-1:0] cnt_lo, cmp_lo, cnt_lo_q;
  logic [CNT_W-1:0]  d_cur, d_nxt, nxt_full, nxt;
  logic reached, past_nxt, per_nz, wrap_set, wrap_hit, arm_req;
  logic glb_q, arm_req_q, armed_q, wrap_q, catch_q, irq_q;
  logic armed_d, wrap_d, catch_d, fire;

  assign cnt_lo   = cnt_i[DATA_W-1:0];
  assign cmp_lo   = cmp_i[DATA_W-1:0];
  assign d_cur    = cnt_i - cmp_i;
  assign nxt_full = cmp_i + per_i;
  assign nxt      = narrow_i ? {{DATA_W{1'b0}}, nxt_full[DATA_W-1:0]} : nxt_full;
  assign d_nxt    = cnt_i - nxt;

  // signed distance in the active width
  assign reached  = narrow_i ? !d_cur[DATA_W-1] : !d_cur[CNT_W-1];
  assign past_nxt = narrow_i ? (!d_nxt[DATA_W-1] && (d_nxt[DATA_W-1:0] != '0))
                             : (!d_nxt[CNT_W-1] && (d_nxt != '0));
  assign per_nz   = narrow_i ? (per_i[DATA_W-1:0] != '0) : (per_i != '0);

  assign wrap_set = narrow_i && !periodic_i && (cmp_lo < cnt_lo) && d_cur[DATA_W-1];
  assign wrap_hit = wrap_q && ((&cnt_lo) || (cnt_lo < cnt_lo_q));
  assign arm_req  = glb_en_i && (cmp_wr_i || (!glb_q && (cmp_i != '1)));

  always_comb begin
    fire    = 1'b0;
    adv_o   = 1'b0;
    armed_d = armed_q;
    wrap_d  = wrap_q;
    catch_d = catch_q;
    if (!glb_en_i) begin
      armed_d = 1'b0;
      wrap_d  = 1'b0;
      catch_d = 1'b0;
    end else if (arm_req_q) begin
      armed_d = 1'b1;
      wrap_d  = wrap_set;
      catch_d = 1'b0;
    end else if (armed_q && !cmp_wr_i) begin
      if (wrap_hit) begin
        fire   = 1'b1;
        wrap_d = 1'b0;
      end else if (reached && !wrap_q) begin
        if (periodic_i && per_nz) begin
          adv_o   = 1'b1;
          fire    = !catch_q;
          catch_d = past_nxt;
        end else begin
          fire    = 1'b1;
          armed_d = 1'b0;
        end
      end else begin
        catch_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_q     <= 1'b0;
      arm_req_q <= 1'b0;
      armed_q   <= 1'b0;
      wrap_q    <= 1'b0;
      catch_q   <= 1'b0;
      irq_q     <= 1'b0;
      cnt_lo_q  <= '0;
    end else begin
      glb_q     <= glb_en_i;
      arm_req_q <= arm_req;
      armed_q   <= armed_d;
      wrap_q    <= wrap_d;
      catch_q   <= catch_d;
      irq_q     <= fire && chan_en_i && glb_en_i;
      cnt_lo_q  <= cnt_lo;
    end
  end

  assign adv_val_o = nxt;
  assign irq_o     = irq_q;
endmodule

// File: rtl/evt_cmp_chan.sv
module evt_cmp_chan #(
  parameter  int DATA_W = 32,
  localparam int CNT_W  = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              glb_en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic chan_en, periodic, narrow, setval, cmp_wr, adv;
  logic [CNT_W-1:0] cmp_q, per_q, adv_val;

  evt_cmp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .adv_i      (adv),
    .adv_val_i  (adv_val),
    .rdata_o    (rdata_o),
    .chan_en_o  (chan_en),
    .periodic_o (periodic),
    .narrow_o   (narrow),
    .setval_o   (setval),
    .cmp_o      (cmp_q),
    .per_o      (per_q),
    .cmp_wr_o   (cmp_wr)
  );

  evt_cmp_match #(.DATA_W(DATA_W)) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .glb_en_i   (glb_en_i),
    .cnt_i      (cnt_i),
    .chan_en_i  (chan_en),
    .periodic_i (periodic),
    .narrow_i   (narrow),
    .cmp_i      (cmp_q),
    .per_i      (per_q),
    .cmp_wr_i   (cmp_wr),
    .adv_o      (adv),
    .adv_val_o  (adv_val),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/evt_cmp_chk.sv
module evt_cmp_chk
  import evt_cmp_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int CNT_W  = 2 * DATA_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             glb_en_i,
  input logic             wr_en_i,
  input logic [2:0]       addr_i,
  input logic             irq_o,
  input logic             chan_en,
  input logic             setval,
  input logic             periodic,
  input logic             narrow,
  input logic [CNT_W-1:0] cmp_q,
  input logic [CNT_W-1:0] per_q
);
  logic cmp_word_wr;
  assign cmp_word_wr = wr_en_i && ((addr_i == W_CMP_LO) || (addr_i == W_CMP_HI));

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(chan_en && glb_en_i)); // R6

  AST_SETVAL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_word_wr |=> !setval); // R3

  AST_PERIOD_WRITE_KEEPS_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_word_wr && periodic && !setval) |=> $stable(cmp_q)); // R2

  AST_NARROW_TRUNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    narrow |-> (cmp_q[CNT_W-1:DATA_W] == '0) && (per_q[CNT_W-1:DATA_W-1] == '0)); // R4

  AST_PERIOD_MSB_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !narrow |-> !per_q[CNT_W-1]); // R5
endmodule

bind evt_cmp_chan evt_cmp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .glb_en_i (glb_en_i),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .irq_o    (irq_o),
  .chan_en  (chan_en),
  .setval   (setval),
  .periodic (periodic),
  .narrow   (narrow),
  .cmp_q    (cmp_q),
  .per_q    (per_q)
);

// File: tb/sim_evt_cmp_chan.sv
module sim_evt_cmp_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glb_en = 1'b1;
  logic [63:0] cnt = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  evt_cmp_chan u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .glb_en_i (glb_en),
    .cnt_i    (cnt),
    .wr_en_i  (wr_en),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .irq_o    (irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    chk(tag, {32'h0, rdata}, {32'h0, exp});
  endtask

  task automatic tick(input logic [63:0] c, input logic exp, input string tag);
    cnt = c;
    @(negedge clk);
    chk(tag, {63'h0, irq}, {63'h0, exp});
  endtask

  task automatic t_reset;
    chk("R10 irq after reset", {63'h0, irq}, 64'h0);
    rd(3'd0, 32'h30, "R10 cfg reset");
    rd(3'd2, 32'hFFFF_FFFF, "R10 cmp lo reset");
    rd(3'd3, 32'hFFFF_FFFF, "R10 cmp hi reset");
  endtask

  task automatic t_cfg_mask;
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, 32'h3E7E, "R9 cfg write mask");
    wr(3'd0, 32'h0);
    rd(3'd0, 32'h30, "R9 cfg cleared keeps caps");
    wr(3'd1, 32'h1234_5678);
    rd(3'd1, 32'h0000_0C20, "R9 cap word read-only");
  endtask

  task automatic t_oneshot;
    tick(64'd0, 1'b0, "R1 idle");
    wr(3'd0, 32'h44);
    rd(3'd0, 32'h74, "R3 setval set");
    wr(3'd3, 32'h0);
    rd(3'd0, 32'h34, "R3 setval cleared by cmp write");
    wr(3'd2, 32'd100);
    rd(3'd2, 32'd100, "R2 one-shot write loads cmp");
    tick(64'd0, 1'b0, "R1 arm cycle");
    tick(64'd99, 1'b0, "R1 before match");
    tick(64'd100, 1'b1, "R1 match pulse");
    tick(64'd101, 1'b0, "R1 single pulse");
    tick(64'd200, 1'b0, "R1 disarmed");
  endtask

  task automatic t_periodic;
    tick(64'd0, 1'b0, "R7 idle");
    wr(3'd0, 32'h4C);
    wr(3'd3, 32'h0);
    wr(3'd0, 32'h4C);
    wr(3'd2, 32'd1000);
    wr(3'd2, 32'd50);
    rd(3'd2, 32'd1000, "R2 periodic write loads period");
    tick(64'd0, 1'b0, "R7 arm cycle");
    tick(64'd999, 1'b0, "R7 before match");
    tick(64'd1000, 1'b1, "R7 first match");
    tick(64'd1001, 1'b0, "R7 pulse ends");
    tick(64'd1049, 1'b0, "R7 before next period");
    tick(64'd1050, 1'b1, "R7 second period");
    tick(64'd1320, 1'b1, "R7 jump fires once");
    for (int i = 0; i < 5; i++) tick(64'd1320, 1'b0, "R7 silent catch-up");
    rd(3'd2, 32'd1350, "R7 cmp after catch-up");
    tick(64'd1349, 1'b0, "R7 before caught-up match");
    tick(64'd1350, 1'b1, "R7 caught-up match");
  endtask

  task automatic t_narrow_wrap;
    tick(64'd0, 1'b0, "R8 idle");
    wr(3'd0, 32'h204);
    tick(64'h0000_0000_FFFF_FFF0, 1'b0, "R8 counter high");
    wr(3'd3, 32'hABCD_0000);
    wr(3'd2, 32'h10);
    rd(3'd3, 32'h0, "R4 narrow hi reads zero");
    tick(64'h0000_0000_FFFF_FFF0, 1'b0, "R8 arm cycle");
    tick(64'h0000_0000_FFFF_FFFE, 1'b0, "R8 before wrap");
    tick(64'h0000_0000_FFFF_FFFF, 1'b1, "R8 wrap pulse");
    tick(64'h0000_0001_0000_0000, 1'b0, "R8 after wrap");
    tick(64'h0000_0001_0000_000F, 1'b0, "R4 low-word compare");
    tick(64'h0000_0001_0000_0010, 1'b1, "R8 match after wrap");
    tick(64'h0000_0001_0000_0020, 1'b0, "R8 done");
  endtask

  task automatic t_clamp;
    wr(3'd0, 32'h24C);
    wr(3'd2, 32'h100);
    wr(3'd2, 32'h8000_0064);
    tick(64'h0000_0001_0000_0020, 1'b0, "R5 arm cycle");
    tick(64'h0000_0001_0000_0100, 1'b1, "R5 first match");
    tick(64'h0000_0001_0000_0163, 1'b0, "R5 before clamped period");
    tick(64'h0000_0001_0000_0164, 1'b1, "R5 clamped period match");
  endtask

  task automatic t_gating;
    wr(3'd0, 32'h0);
    wr(3'd3, 32'h1);
    wr(3'd2, 32'h200);
    tick(64'h0000_0001_0000_0164, 1'b0, "R6 arm cycle");
    tick(64'h0000_0001_0000_0200, 1'b0, "R6 channel disabled");
    tick(64'h0000_0001_0000_0201, 1'b0, "R6 channel disabled after");
    wr(3'd0, 32'h4);
    glb_en = 1'b0;
    wr(3'd2, 32'h300);
    tick(64'h0000_0001_0000_0300, 1'b0, "R6 global disabled");
    glb_en = 1'b1;
    tick(64'h0000_0001_0000_0300, 1'b0, "R6 global rise");
    tick(64'h0000_0001_0000_0300, 1'b0, "R6 re-arm");
    tick(64'h0000_0001_0000_0300, 1'b1, "R6 fires after re-arm");
  endtask

  task automatic t_level;
    wr(3'd0, 32'h6);
    rd(3'd0, 32'h36, "R11 level bit stored");
    wr(3'd3, 32'h1);
    wr(3'd2, 32'h400);
    tick(64'h0000_0001_0000_0300, 1'b0, "R11 arm cycle");
    tick(64'h0000_0001_0000_0400, 1'b1, "R11 match pulse");
    tick(64'h0000_0001_0000_0400, 1'b0, "R11 still a pulse");
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg_mask();
    t_oneshot();
    t_periodic();
    t_narrow_wrap();
    t_clamp();
    t_gating();
    t_level();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule